// File: doc/BRIEF.md
# Clock-loss lock monitor

This block produces the lock indication for an on-chip clock generator. It observes a reference clock, which is asynchronous to it, from a faster free-running sampling clock. It reports lock once the reference has delivered a programmable number of rising edges in a row, each one close enough to the previous edge. When the reference stops toggling, the lock indication drops within a bounded number of sampling cycles. After that it stays low until the block is reset again. Reset therefore serves as the recovery path whenever the input clock conditions change.

The reset input may be asserted at any moment, and the lock output clears at once. Release of reset is taken through a two-stage synchronizer, so counting restarts on a clean sampling edge. No further action is needed after power-on: as soon as the reference starts toggling steadily, the block acquires lock by itself.

Two parameters set the limits. `SETTLE_EDGES` is the number of consecutive good edges needed for lock. `MAX_GAP` is the largest spacing between edges that still counts as good, measured in sampling cycles. `MAX_GAP` should be set slightly above one reference period expressed in sampling cycles.

Top module: `clk_lock_monitor`

## Requirements
- R1: While `rst_n_i` is low, `locked_o` is low. Asserting `rst_n_i` clears `locked_o` without waiting for a sampling-clock edge.
- R2: After `rst_n_i` rises, `locked_o` stays low for at least the two sampling cycles taken by the reset synchronizer.
- R3: With the reference toggling at a steady spacing of at most `MAX_GAP` cycles, `locked_o` is still low after `SETTLE_EDGES`-1 rising edges. It rises on the third sampling-clock rising edge after the `SETTLE_EDGES`-th reference rising edge.
- R4: Two reference rising edges spaced exactly `MAX_GAP` sampling cycles apart count as consecutive. A spacing of `MAX_GAP`+1 cycles or more does not.
- R5: During acquisition, a pause longer than `MAX_GAP` cycles restarts the edge count. The edge that ends the pause counts as the first edge of a new run.
- R6: A reference that is too slow or absent during acquisition does not latch any failure state. Once steady edges arrive, lock is acquired without a reset.
- R7: While locked, if no reference rising edge arrives within `MAX_GAP` cycles of the previous one, `locked_o` falls. When the reference stops after a rising edge, `locked_o` falls on the (`MAX_GAP`+4)-th sampling-clock rising edge after that reference edge, and is still high on the edge before.
- R8: Once `locked_o` has fallen from high without a reset, it stays low however the reference behaves, until `rst_n_i` is asserted.
- R9: After a reset that follows a loss of lock, the block acquires lock again as in R3.
- R10: Only rising edges of the reference count. A reference that stops in the high state is treated as a stopped clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock, faster than the reference |
| rst_n_i | input | 1 | Active-low reset; asserted asynchronously, released through a synchronizer |
| ref_clk_i | input | 1 | Reference clock under observation, asynchronous to `clk_i` |
| locked_o | output | 1 | High while the reference is judged present and steady |

## Verification
The hardest situations to reach are the two edge-spacing boundaries. One is a spacing of exactly `MAX_GAP` against `MAX_GAP`+1 cycles, both during acquisition and after lock. The other is the cycle-exact moment at which lock falls once the reference freezes. Both depend on the synchronizer latency. The bench therefore changes the reference only on falling edges of the sampling clock, which fixes the latency from a reference edge to the output. It then builds each spacing by counting sampling cycles. The sticky state is reached only through a real loss, after which the reference is restarted at a good rate to show that lock does not return without a reset.

// File: rtl/lkm_pkg.sv
`timescale 1ns/1ps
// Shared types for the clock-loss lock monitor.
package lkm_pkg;

    // Monitor state: searching for a steady reference, locked, or latched loss.
    typedef enum logic [1:0] {
        LKM_ACQUIRE = 2'd0,
        LKM_LOCKED  = 2'd1,
        LKM_LOST    = 2'd2
    } lkm_state_e;

endpackage

// File: rtl/lkm_rst_sync.sv
`timescale 1ns/1ps
// Reset synchronizer.
// Clears its output the moment rst_n_i falls. The output returns high
// only after STAGES rising edges of clk_i.
// Assumes STAGES >= 2.
module lkm_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    output logic rst_n_o
);

    logic [STAGES-1:0] chain_q;

    // Shift ones into the chain once reset has lifted.
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b1};
        end
    end

    assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/lkm_edge_det.sv
`timescale 1ns/1ps
// Reference edge detector.
// Brings the asynchronous reference through a STAGES-flop synchronizer and
// flags each rising edge with a one-cycle pulse in the clk_i domain.
// Assumes the reference stays high and low for more than one clk_i period each.
module lkm_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic ref_i,
    output logic edge_o
);

    logic [STAGES:0] shift_q;

    // Synchronizer stages plus one history flop for edge detection.
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[STAGES-1:0], ref_i};
        end
    end

    assign edge_o = shift_q[STAGES-1] & ~shift_q[STAGES];

endmodule

// File: rtl/lkm_gap_timer.sv
`timescale 1ns/1ps
// Edge gap timer.
// Counts clk_i cycles since the last edge pulse and saturates at MAX_GAP+1.
// overdue_o is high while MAX_GAP+1 or more cycles have passed without an edge.
// Assumes MAX_GAP >= 1.
module lkm_gap_timer #(
    parameter int MAX_GAP = 12
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic edge_i,
    output logic overdue_o
);

    localparam int CW = $clog2(MAX_GAP + 2);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_GAP + 1);

    logic [CW-1:0] gap_q;

    // Restart at one on an edge, otherwise count up to the saturation limit.
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            gap_q <= '0;
        end else if (edge_i) begin
            gap_q <= CW'(1);
        end else if (gap_q != LIMIT) begin
            gap_q <= gap_q + CW'(1);
        end
    end

    assign overdue_o = (gap_q == LIMIT);

endmodule

// File: rtl/lkm_lock_fsm.sv
`timescale 1ns/1ps
// Lock decision state machine.
// Counts consecutive on-time edges while acquiring and enters LOCKED after
// SETTLE_EDGES of them. Moves to a sticky LOST state when an edge is overdue.
// Leaves LOST only through reset.
// Assumes SETTLE_EDGES >= 1.
module lkm_lock_fsm
    import lkm_pkg::*;
#(
    parameter int SETTLE_EDGES = 8
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic edge_i,
    input  logic overdue_i,
    output logic locked_o
);

    localparam int RW = $clog2(SETTLE_EDGES + 1);
    localparam logic [RW-1:0] RUN_DONE = RW'(SETTLE_EDGES);

    lkm_state_e    state_q, state_d;
    logic [RW-1:0] run_q, run_d;
    logic [RW-1:0] run_next;
    logic          lock_q;

    // Length of the run if the current edge is counted.
    assign run_next = overdue_i ? RW'(1) : run_q + RW'(1);

    // Next state and next run length.
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        unique case (state_q)
            LKM_ACQUIRE: begin
                if (edge_i) begin
                    run_d = run_next;
                    if (run_next >= RUN_DONE) begin
                        state_d = LKM_LOCKED;
                    end
                end else if (overdue_i) begin
                    run_d = '0;
                end
            end
            LKM_LOCKED: begin
                if (overdue_i) begin
                    state_d = LKM_LOST;
                end
            end
            LKM_LOST: begin
                state_d = LKM_LOST;
            end
            default: begin
                state_d = LKM_ACQUIRE;
                run_d   = '0;
            end
        endcase
    end

    // State, run counter and registered lock flag.
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            state_q <= LKM_ACQUIRE;
            run_q   <= '0;
            lock_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
            lock_q  <= (state_d == LKM_LOCKED);
        end
    end

    assign locked_o = lock_q;

endmodule

// File: rtl/clk_lock_monitor.sv
`timescale 1ns/1ps
// Clock-loss lock monitor, top level.
// Watches ref_clk_i from clk_i and raises locked_o after SETTLE_EDGES
// consecutive reference rising edges, each spaced at most MAX_GAP cycles apart.
// Loss of lock is sticky until reset.
// Assumes clk_i runs at least a few times faster than ref_clk_i.
module clk_lock_monitor #(
    parameter int SETTLE_EDGES = 8,
    parameter int MAX_GAP      = 12,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic ref_clk_i,
    output logic locked_o
);

    logic rst_sync_n;
    logic ref_edge;
    logic gap_over;

    lkm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .rst_n_o (rst_sync_n)
    );

    lkm_edge_det #(.STAGES(SYNC_STAGES)) u_edge_det (
        .clk_i   (clk_i),
        .rst_n_i (rst_sync_n),
        .ref_i   (ref_clk_i),
        .edge_o  (ref_edge)
    );

    lkm_gap_timer #(.MAX_GAP(MAX_GAP)) u_gap_timer (
        .clk_i     (clk_i),
        .rst_n_i   (rst_sync_n),
        .edge_i    (ref_edge),
        .overdue_o (gap_over)
    );

    lkm_lock_fsm #(.SETTLE_EDGES(SETTLE_EDGES)) u_lock_fsm (
        .clk_i     (clk_i),
        .rst_n_i   (rst_sync_n),
        .edge_i    (ref_edge),
        .overdue_i (gap_over),
        .locked_o  (locked_o)
    );

endmodule

// File: rtl/clk_lock_monitor_chk.sv
`timescale 1ns/1ps
// Property checker for clk_lock_monitor, attached with bind.
// Observes the top-level ports plus the edge pulse and overdue flag
// that pass between the submodules.
module clk_lock_monitor_chk (
    input logic clk_i,
    input logic rst_n_i,
    input logic locked_o,
    input logic edge_pulse,
    input logic overdue
);

    logic lost_seen_q;

    // Remember that lock has fallen since the last reset.
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            lost_seen_q <= 1'b0;
        end else if (!locked_o && $past(locked_o)) begin
            lost_seen_q <= 1'b1;
        end
    end

    // R1
    reset_clears_lock_chk: assert property (@(posedge clk_i)
        !rst_n_i |-> !locked_o);

    // R2
    release_holds_low_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !$past(rst_n_i) |-> !locked_o);

    // R3
    lock_follows_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(locked_o) |-> $past(edge_pulse));

    // R7
    overdue_drops_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (overdue && locked_o) |=> !locked_o);

    // R8
    loss_is_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        lost_seen_q |-> !locked_o);

endmodule

bind clk_lock_monitor clk_lock_monitor_chk u_chk (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .locked_o   (locked_o),
    .edge_pulse (ref_edge),
    .overdue    (gap_over)
);

// File: tb/test_clk_lock_monitor.sv
`timescale 1ns/1ps
// Directed bench for clk_lock_monitor. The reference is changed only on
// falling edges of the sampling clock, and outputs are sampled there too.
module test_clk_lock_monitor;

    localparam int SETTLE = 8;
    localparam int GAP    = 12;

    logic clk = 1'b0;
    logic rst_n;
    logic ref_clk;
    logic locked;
    int   checks = 0;
    int   errors = 0;

    always #2.5 clk = ~clk;

    clk_lock_monitor #(.SETTLE_EDGES(SETTLE), .MAX_GAP(GAP)) i_clk_lock_monitor (
        .clk_i     (clk),
        .rst_n_i   (rst_n),
        .ref_clk_i (ref_clk),
        .locked_o  (locked)
    );

    task automatic check(input logic expected, input string req);
        checks++;
        if (locked !== expected) begin
            errors++;
            $display("FAIL %s: locked_o=%b expected %b at %0t", req, locked, expected, $time);
        end
    endtask

    // One reference rising edge: high for hi cycles; the next call rises hi+lo cycles later.
    task automatic send_edge(input int hi, input int lo);
        @(negedge clk) ref_clk = 1'b1;
        repeat (hi) @(negedge clk);
        ref_clk = 1'b0;
        repeat (lo - 1) @(negedge clk);
    endtask

    task automatic send_edges(input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) send_edge(hi, lo);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ref_clk = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        ref_clk = 1'b0;
        repeat (3) @(negedge clk);
        check(1'b0, "R1 low during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b0, "R2 first cycle after release");
        @(negedge clk);
        check(1'b0, "R2 second cycle after release");
        repeat (2) @(negedge clk);
    endtask

    task automatic t_acquire();
        send_edges(SETTLE - 1, 4, 4);
        check(1'b0, "R3 one edge short");
        send_edge(4, 4);
        check(1'b1, "R3 lock after settle edges");
    endtask

    task automatic t_async_reset();
        @(negedge clk);
        #1 rst_n = 1'b0;
        #0.5;
        check(1'b0, "R1 async clear before clock edge");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_gap_accept();
        do_reset();
        send_edges(SETTLE, 6, GAP - 6);
        check(1'b1, "R4 spacing of MAX_GAP counts");
        send_edge(4, GAP - 4);
        send_edges(2, 4, 4);
        check(1'b1, "R4 spacing of MAX_GAP keeps lock");
    endtask

    task automatic t_slow_ref();
        do_reset();
        send_edges(10, 6, GAP + 1 - 6);
        check(1'b0, "R4 spacing MAX_GAP+1 never locks");
        send_edges(SETTLE - 1, 4, 4);
        check(1'b0, "R6 fresh run one edge short");
        send_edge(4, 4);
        check(1'b1, "R6 lock without reset after slow ref");
    endtask

    task automatic t_interrupt();
        do_reset();
        send_edges(5, 4, 4);
        repeat (20) @(negedge clk);
        send_edges(SETTLE - 1, 4, 4);
        check(1'b0, "R5 pause restarts count");
        send_edge(4, 4);
        check(1'b1, "R5 lock after full new run");
    endtask

    task automatic t_loss_stop_high();
        @(negedge clk) ref_clk = 1'b1;
        repeat (GAP + 3) @(negedge clk);
        check(1'b1, "R7 still locked on edge before loss");
        @(negedge clk);
        check(1'b0, "R10 stuck-high reference drops lock");
    endtask

    task automatic t_sticky();
        ref_clk = 1'b0;
        send_edges(20, 4, 4);
        check(1'b0, "R8 loss stays after ref resumes");
    endtask

    task automatic t_reacquire();
        do_reset();
        send_edges(SETTLE - 1, 4, 4);
        check(1'b0, "R9 reacquire one edge short");
        send_edge(4, 4);
        check(1'b1, "R9 reacquired after reset");
    endtask

    task automatic t_gap_loss();
        send_edge(4, GAP + 1 - 4);
        send_edge(4, 4);
        check(1'b0, "R7 spacing MAX_GAP+1 drops lock");
        send_edges(12, 4, 4);
        check(1'b0, "R8 stays low after gap loss");
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        t_reset_state();
        t_acquire();
        t_async_reset();
        t_gap_accept();
        t_slow_ref();
        t_interrupt();
        t_loss_stop_high();
        t_sticky();
        t_reacquire();
        t_gap_loss();
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

endmodule